// File: doc/BRIEF.md
# Accumulator Operate Unit with Carry Link

This block runs the register-to-register class of a 16-bit accumulator machine that keeps one carry flag. Each instruction names a source and a destination among four accumulators. The unit joins a base carry, picked by a carry-control field, onto the source data to form a 17-bit word. It applies one of eight functions to that word, and may then rotate the 17-bit word by one place through the carry or exchange the two data bytes. It tests one of eight skip conditions on the final word. Unless the no-load bit is set, it writes the data back to the destination accumulator and the top bit back to the carry.

The datapath is combinational. Accumulators and carry change on one rising clock edge when the execute strobe is high. A separate load port fills an accumulator with a word from outside, for example from the memory path. The skip output asks the surrounding sequencer to step its program counter one extra place. Fetch, addressing and memory are left to the neighbouring blocks.

The instruction input is 15 bits wide, and its fields are decoded at fixed places. Bits [14:13] select the source, bits [12:11] select the destination, bits [10:8] hold the function, bits [7:6] the shift, bits [5:4] the carry control, bit [3] the no-load flag, and bits [2:0] the skip test.

Top module: `opalu_top`

## Requirements
- R1: After reset, all four accumulators and the carry read zero.
- R2: Carry control in bits [5:4] sets the base carry: 0 keeps the current carry, 1 forces 0, 2 forces 1, 3 inverts the current carry.
- R3: Function bits [10:8] work on the 17-bit word {base carry, source}: 0 inverts the data, 1 negates, 2 moves, 3 adds one, 4 adds the inverted source to the destination, 5 subtracts the source from the destination (inverted source plus destination plus one), 6 adds source and destination, 7 is bitwise AND. A carry out of data bit 15 inverts bit 16, and the result keeps 17 bits.
- R4: Functions 0 (invert) and 7 (AND) pass the base carry through unchanged.
- R5: Shift bits [7:6]: 0 leaves the word as it is, 1 rotates the 17-bit word left by one (bit 16 goes to bit 0), 2 rotates it right by one (bit 0 goes to bit 16), 3 swaps the two data bytes and leaves bit 16 alone.
- R6: Skip bits [2:0] test the final word, with C being bit 16 and Z meaning the data bits are all zero: 0 never, 1 always, 2 !C, 3 C, 4 Z, 5 !Z, 6 !C or Z, 7 C and !Z.
- R7: When no-load bit [3] is 1, neither the destination accumulator nor the carry changes, but skip_o is still computed from the final word.
- R8: Source bits [14:13] and destination bits [12:11] pick the accumulators. The result reaches the destination and the carry on the rising edge at which exec_i is high. Without exec_i or a load, no state changes.
- R9: When ld_en_i is high and exec_i is low, ld_data_i is written to the accumulator ld_sel_i at the edge. A load asserted together with exec_i is ignored.
- R10: While exec_i is low, skip_o, wb_acc_en_o and wb_carry_en_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_i | input | 1 | Execute the instruction on instr_i at this edge |
| instr_i | input | 15 | Instruction fields (layout above) |
| ld_en_i | input | 1 | External accumulator load strobe |
| ld_sel_i | input | 2 | Accumulator to load |
| ld_data_i | input | 16 | Load data |
| wb_acc_en_o | output | 1 | Accumulator write-back in this cycle |
| wb_sel_o | output | 2 | Destination accumulator |
| wb_data_o | output | 16 | Result data |
| wb_carry_en_o | output | 1 | Carry write-back in this cycle |
| wb_carry_o | output | 1 | Result carry (bit 16 of the final word) |
| skip_o | output | 1 | Skip request for the next instruction |
| acc_flat_o | output | 64 | All accumulators, entry i at bits [16i+15:16i] |
| carry_o | output | 1 | Current carry flag |

## Verification
The bench builds the block with its default values: 16-bit data and four accumulators. With these values every source and destination pairing, the byte swap on a true 8-bit split, and carry out of bit 15 can be reached from directed values such as 0xFFFF plus one or the negation of zero. A 17-bit reference written with integer arithmetic predicts the skip, the write-back data and the next state of every accumulator on every clock. Random instructions mixed with loads, including loads that collide with execute, then cover the combinations of carry control, function, shift and skip.

// File: rtl/opalu_pkg.sv
package opalu_pkg;

  typedef enum logic [2:0] {
    FN_COM, FN_NEG, FN_MOV, FN_INC, FN_ADC, FN_SUB, FN_ADD, FN_AND
  } fn_e;

  typedef enum logic [1:0] {
    SH_NONE, SH_ROL, SH_ROR, SH_SWAP
  } sh_e;

  typedef enum logic [1:0] {
    CY_KEEP, CY_ZERO, CY_ONE, CY_FLIP
  } cy_e;

  typedef enum logic [2:0] {
    SK_NEVER, SK_ALWAYS, SK_CZ, SK_CNZ, SK_RZ, SK_RNZ, SK_CZ_OR_RZ, SK_C_AND_RNZ
  } sk_e;

  // low 11 bits of the instruction, most significant field first
  typedef struct packed {
    fn_e  fn;
    sh_e  sh;
    cy_e  cy;
    logic noload;
    sk_e  sk;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/opalu_core.sv
module opalu_core
  import opalu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic         carry_i,
  input  ctl_t         ctl_i,
  output logic [W:0]   res_o
);

  localparam int H = W / 2;
  localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

  logic       base_c;
  logic [W:0] s_ext;
  logic [W:0] n_ext;
  logic [W:0] d_ext;
  logic [W:0] fn_val;

  always_comb begin
    unique case (ctl_i.cy)
      CY_KEEP: base_c = carry_i;
      CY_ZERO: base_c = 1'b0;
      CY_ONE:  base_c = 1'b1;
      default: base_c = ~carry_i;
    endcase
  end

  assign s_ext = {base_c, src_i};
  assign n_ext = {base_c, ~src_i};
  assign d_ext = {1'b0, dst_i};

  always_comb begin
    unique case (ctl_i.fn)
      FN_COM:  fn_val = n_ext;
      FN_NEG:  fn_val = n_ext + ONE;
      FN_MOV:  fn_val = s_ext;
      FN_INC:  fn_val = s_ext + ONE;
      FN_ADC:  fn_val = n_ext + d_ext;
      FN_SUB:  fn_val = n_ext + d_ext + ONE;
      FN_ADD:  fn_val = s_ext + d_ext;
      default: fn_val = {base_c, src_i & dst_i};
    endcase
  end

  always_comb begin
    unique case (ctl_i.sh)
      SH_ROL:  res_o = {fn_val[W-1:0], fn_val[W]};
      SH_ROR:  res_o = {fn_val[0], fn_val[W:1]};
      SH_SWAP: res_o = {fn_val[W], fn_val[H-1:0], fn_val[W-1:H]};
      default: res_o = fn_val;
    endcase
  end

endmodule

// File: rtl/opalu_skip.sv
module opalu_skip
  import opalu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W:0] res_i,
  input  sk_e        sk_i,
  output logic       hit_o
);

  logic c_bit;
  logic z_bit;

  assign c_bit = res_i[W];
  assign z_bit = ~|res_i[W-1:0];

  always_comb begin
    unique case (sk_i)
      SK_NEVER:    hit_o = 1'b0;
      SK_ALWAYS:   hit_o = 1'b1;
      SK_CZ:       hit_o = ~c_bit;
      SK_CNZ:      hit_o = c_bit;
      SK_RZ:       hit_o = z_bit;
      SK_RNZ:      hit_o = ~z_bit;
      SK_CZ_OR_RZ: hit_o = ~c_bit | z_bit;
      default:     hit_o = c_bit & ~z_bit;
    endcase
  end

endmodule

// File: rtl/opalu_regfile.sv
module opalu_regfile #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic [$clog2(N)-1:0] wr_sel_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              c_wr_en_i,
  input  logic              c_wr_data_i,
  input  logic              ld_en_i,
  input  logic [$clog2(N)-1:0] ld_sel_i,
  input  logic [W-1:0]      ld_data_i,
  output logic [N*W-1:0]    acc_flat_o,
  output logic              carry_o
);

  localparam int SW = $clog2(N);

  logic         carry_q;

  for (genvar i = 0; i < N; i++) begin : g_acc
    logic [W-1:0] acc_q;
    logic [W-1:0] acc_d;
    logic         acc_en;

    always_comb begin
      acc_en = 1'b0;
      acc_d  = acc_q;
      if (wr_en_i && (wr_sel_i == SW'(i))) begin
        acc_en = 1'b1;
        acc_d  = wr_data_i;
      end else if (ld_en_i && (ld_sel_i == SW'(i))) begin
        acc_en = 1'b1;
        acc_d  = ld_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        acc_q <= '0;
      end else if (acc_en) begin
        acc_q <= acc_d;
      end
    end

    assign acc_flat_o[i*W +: W] = acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      carry_q <= 1'b0;
    end else if (c_wr_en_i) begin
      carry_q <= c_wr_data_i;
    end
  end

  assign carry_o = carry_q;

endmodule

// File: rtl/opalu_top.sv
module opalu_top
  import opalu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_ACC = 4,
  localparam int SEL_W   = $clog2(NUM_ACC),
  localparam int INSTR_W = 2 * SEL_W + CTL_W
) (
  input  logic                      clk_i,
  input  logic                      rst_n_i,
  input  logic                      exec_i,
  input  logic [INSTR_W-1:0]        instr_i,
  input  logic                      ld_en_i,
  input  logic [SEL_W-1:0]          ld_sel_i,
  input  logic [DATA_W-1:0]         ld_data_i,
  output logic                      wb_acc_en_o,
  output logic [SEL_W-1:0]          wb_sel_o,
  output logic [DATA_W-1:0]         wb_data_o,
  output logic                      wb_carry_en_o,
  output logic                      wb_carry_o,
  output logic                      skip_o,
  output logic [NUM_ACC*DATA_W-1:0] acc_flat_o,
  output logic                      carry_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_q;
  ctl_t              ctl;
  logic [SEL_W-1:0]  src_sel;
  logic [SEL_W-1:0]  dst_sel;
  logic [DATA_W-1:0] src_val;
  logic [DATA_W-1:0] dst_val;
  logic [DATA_W:0]   res;
  logic              hit;
  logic              commit;

  // assert asynchronously, release on the second clock edge
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q = rst_sync_q[1];

  assign ctl     = ctl_t'(instr_i[CTL_W-1:0]);
  assign src_sel = instr_i[INSTR_W-1 -: SEL_W];
  assign dst_sel = instr_i[INSTR_W-SEL_W-1 -: SEL_W];
  assign src_val = acc_flat_o[src_sel*DATA_W +: DATA_W];
  assign dst_val = acc_flat_o[dst_sel*DATA_W +: DATA_W];

  opalu_core #(.W(DATA_W)) core_i (
    .src_i   (src_val),
    .dst_i   (dst_val),
    .carry_i (carry_o),
    .ctl_i   (ctl),
    .res_o   (res)
  );

  opalu_skip #(.W(DATA_W)) skip_i (
    .res_i (res),
    .sk_i  (ctl.sk),
    .hit_o (hit)
  );

  assign commit        = exec_i & ~ctl.noload;
  assign wb_acc_en_o   = commit;
  assign wb_carry_en_o = commit;
  assign wb_sel_o      = dst_sel;
  assign wb_data_o     = res[DATA_W-1:0];
  assign wb_carry_o    = res[DATA_W];
  assign skip_o        = exec_i & hit;

  opalu_regfile #(.W(DATA_W), .N(NUM_ACC)) rf_i (
    .clk_i       (clk_i),
    .rst_n_i     (rst_q),
    .wr_en_i     (commit),
    .wr_sel_i    (dst_sel),
    .wr_data_i   (res[DATA_W-1:0]),
    .c_wr_en_i   (commit),
    .c_wr_data_i (res[DATA_W]),
    .ld_en_i     (ld_en_i & ~exec_i),
    .ld_sel_i    (ld_sel_i),
    .ld_data_i   (ld_data_i),
    .acc_flat_o  (acc_flat_o),
    .carry_o     (carry_o)
  );

endmodule

// File: rtl/opalu_chk.sv
module opalu_chk #(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int SW = 2,
  parameter int IW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exec_i,
  input logic [IW-1:0] instr_i,
  input logic          ld_en_i,
  input logic          wb_acc_en_o,
  input logic [SW-1:0] wb_sel_o,
  input logic [W-1:0]  wb_data_o,
  input logic          wb_carry_o,
  input logic          wb_carry_en_o,
  input logic          skip_o,
  input logic [N*W-1:0] acc_flat_o,
  input logic          carry_o
);

  logic          en_q;
  logic [SW-1:0] sel_q;
  logic [W-1:0]  data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      data_q <= '0;
    end else begin
      en_q   <= wb_acc_en_o;
      sel_q  <= wb_sel_o;
      data_q <= wb_data_o;
    end
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |-> (!skip_o && !wb_acc_en_o && !wb_carry_en_o));

  assert_noload_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i[3]) |=> ($stable(acc_flat_o) && $stable(carry_o)));

  assert_carry_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !instr_i[3]) |=> (carry_o == $past(wb_carry_o)));

  assert_dest_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (acc_flat_o[sel_q*W +: W] == data_q));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_i && !ld_en_i) |=> ($stable(acc_flat_o) && $stable(carry_o)));

  assert_skip_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i[2:0] == 3'd0) |-> !skip_o);

  assert_skip_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i[2:0] == 3'd1) |-> skip_o);

  assert_com_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i[10:8] == 3'd0 && instr_i[7:6] == 2'd0 && instr_i[5:4] == 2'd0)
      |-> (wb_carry_o == carry_o));

endmodule

bind opalu_top opalu_chk #(
  .W(DATA_W), .N(NUM_ACC), .SW(SEL_W), .IW(INSTR_W)
) chk_i (
  .clk           (clk_i),
  .rst_n         (rst_q),
  .exec_i        (exec_i),
  .instr_i       (instr_i),
  .ld_en_i       (ld_en_i),
  .wb_acc_en_o   (wb_acc_en_o),
  .wb_sel_o      (wb_sel_o),
  .wb_data_o     (wb_data_o),
  .wb_carry_o    (wb_carry_o),
  .wb_carry_en_o (wb_carry_en_o),
  .skip_o        (skip_o),
  .acc_flat_o    (acc_flat_o),
  .carry_o       (carry_o)
);

// File: tb/opalu_tb.sv
`timescale 1ns/1ps
module opalu_top_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_n_i;
  logic        exec_i;
  logic [14:0] instr_i;
  logic        ld_en_i;
  logic [1:0]  ld_sel_i;
  logic [15:0] ld_data_i;
  logic        wb_acc_en_o;
  logic [1:0]  wb_sel_o;
  logic [15:0] wb_data_o;
  logic        wb_carry_en_o;
  logic        wb_carry_o;
  logic        skip_o;
  logic [63:0] acc_flat_o;
  logic        carry_o;

  int checks   = 0;
  int failures = 0;
  int m_acc[4];
  int m_c;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  opalu_top dut_i (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(int s, int d, int fn, int sh, int cy, int nl, int sk);
    return 15'((s << 13) | (d << 11) | (fn << 8) | (sh << 6) | (cy << 4) | (nl << 3) | sk);
  endfunction

  function automatic int ref_val(int s, int d, int c, int fn, int sh, int cy);
    int base;
    int v;
    base = (cy == 0) ? c : (cy == 1) ? 0 : (cy == 2) ? 1 : (c ^ 1);
    v = s | (base << 16);
    case (fn)
      0: v = v ^ 'hFFFF;
      1: v = ((v ^ 'hFFFF) + 1) & 'h1FFFF;
      2: ;
      3: v = (v + 1) & 'h1FFFF;
      4: v = ((v ^ 'hFFFF) + d) & 'h1FFFF;
      5: v = ((v ^ 'hFFFF) + d + 1) & 'h1FFFF;
      6: v = (v + d) & 'h1FFFF;
      default: v = v & (d | 'h10000);
    endcase
    case (sh)
      1: v = ((v << 1) | (v >> 16)) & 'h1FFFF;
      2: v = ((v >> 1) | (v << 16)) & 'h1FFFF;
      3: v = ((v & 'hFF) << 8) | ((v >> 8) & 'hFF) | (v & 'h10000);
      default: ;
    endcase
    return v;
  endfunction

  function automatic bit ref_skip(int v, int sk);
    case (sk)
      0: return 0;
      1: return 1;
      2: return v < 'h10000;
      3: return v >= 'h10000;
      4: return (v & 'hFFFF) == 0;
      5: return (v & 'hFFFF) != 0;
      6: return v <= 'h10000;
      default: return v > 'h10000;
    endcase
  endfunction

  task automatic check_state(input string tag);
    for (int i = 0; i < 4; i++)
      check(acc_flat_o[i*16 +: 16] == 16'(m_acc[i]), tag, $sformatf("acc%0d", i),
            acc_flat_o[i*16 +: 16], m_acc[i]);
    check(carry_o == 1'(m_c), tag, "carry", carry_o, m_c);
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic step(input bit ex, input logic [14:0] ins, input bit ld,
                      input int lsel, input int ldat, input string tag);
    int s, d, v, fn, sh, cy, nl, sk;
    bit exp_skip;
    check_state(tag);
    exec_i = ex; instr_i = ins; ld_en_i = ld;
    ld_sel_i = 2'(lsel); ld_data_i = 16'(ldat);
    #1;
    s  = m_acc[ins[14:13]]; d = m_acc[ins[12:11]];
    fn = ins[10:8]; sh = ins[7:6]; cy = ins[5:4]; nl = ins[3]; sk = ins[2:0];
    v  = ref_val(s, d, m_c, fn, sh, cy);
    exp_skip = ex ? ref_skip(v, sk) : 1'b0;
    check(skip_o == exp_skip, tag, "skip", skip_o, exp_skip);
    check(wb_acc_en_o == (ex && !nl), tag, "wb_en", wb_acc_en_o, ex && !nl);
    if (ex) begin
      check(wb_data_o == 16'(v & 'hFFFF), tag, "wb_data", wb_data_o, v & 'hFFFF);
      check(wb_carry_o == 1'(v >> 16), tag, "wb_carry", wb_carry_o, v >> 16);
      if (!nl) begin
        m_acc[ins[12:11]] = v & 'hFFFF;
        m_c = v >> 16;
      end
    end else if (ld) begin
      m_acc[lsel] = ldat & 'hFFFF;
    end
    @(negedge clk_i);
  endtask

  task automatic op(input logic [14:0] ins, input string tag);
    step(1'b1, ins, 1'b0, 0, 0, tag);
  endtask

  task automatic load(input int sel, input int dat, input string tag);
    step(1'b0, 15'd0, 1'b1, sel, dat, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_acc[i] = 0;
    m_c = 0;
    rst_n_i = 1'b0; exec_i = 1'b0; instr_i = '0; ld_en_i = 1'b0;
    ld_sel_i = '0; ld_data_i = '0;
    repeat (3) @(negedge clk_i);
    rst_n_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check_state("R1");

    // R9: loads, and a load colliding with execute
    load(0, 'h1234, "R9");
    load(1, 'hFFFF, "R9");
    load(2, 'h00F0, "R9");
    load(3, 'h8001, "R9");
    step(1'b1, mk(0, 0, 2, 0, 0, 1, 0), 1'b1, 2, 'hDEAD, "R9");
    check_state("R9");

    // R2: carry control with MOV acc0 -> acc0
    op(mk(0, 0, 2, 0, 2, 0, 0), "R2");
    op(mk(0, 0, 2, 0, 0, 0, 3), "R2");
    op(mk(0, 0, 2, 0, 3, 0, 0), "R2");
    op(mk(0, 0, 2, 0, 1, 0, 2), "R2");

    // R3: arithmetic with carry toggle
    op(mk(1, 2, 6, 0, 1, 0, 0), "R3");
    load(1, 'hFFFF, "R3");
    op(mk(1, 1, 3, 0, 1, 0, 0), "R3");
    load(1, 0, "R3");
    op(mk(1, 1, 1, 0, 1, 0, 3), "R3");
    load(1, 5, "R3");
    load(2, 3, "R3");
    op(mk(1, 2, 5, 0, 1, 0, 0), "R3");
    op(mk(1, 2, 4, 0, 2, 0, 0), "R3");
    op(mk(3, 0, 6, 0, 0, 0, 0), "R3");

    // R4: invert and AND keep base carry
    op(mk(3, 1, 0, 0, 2, 0, 0), "R4");
    op(mk(3, 1, 7, 0, 3, 0, 0), "R4");

    // R5: shifts
    load(0, 'h8001, "R5");
    op(mk(0, 0, 2, 1, 1, 0, 0), "R5");
    op(mk(0, 0, 2, 2, 2, 0, 0), "R5");
    load(3, 'h12AB, "R5");
    op(mk(3, 3, 2, 3, 2, 0, 0), "R5");

    // R6: every skip test on zero data with both carries
    load(1, 0, "R6");
    for (int sk = 0; sk < 8; sk++) begin
      op(mk(1, 2, 2, 0, 1, 1, sk), "R6");
      op(mk(1, 2, 2, 0, 2, 1, sk), "R6");
      op(mk(0, 2, 2, 0, 2, 1, sk), "R6");
    end

    // R7: no-load keeps state, skip still evaluated
    op(mk(0, 1, 6, 0, 3, 1, 5), "R7");
    check_state("R7");

    // R10 / R8: idle cycles
    step(1'b0, mk(0, 1, 2, 0, 2, 0, 1), 1'b0, 0, 0, "R10");
    step(1'b0, mk(2, 2, 3, 0, 2, 0, 1), 1'b0, 0, 0, "R8");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit ex;
      ex = ($urandom % 4) != 0;
      step(ex, 15'($urandom), ($urandom % 2) == 1, $urandom % 4, $urandom % 65536, "R8");
    end
    check_state("R8");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule